// File: doc/BRIEF.md
# Multiplierless Signed-Digit FIR Filter

This block is an eight-tap FIR filter with fixed coefficients that uses no multipliers. Every coefficient is a small constant with at most two non-zero signed digits (canonical signed-digit form), so each tap product is formed from two copies of the input sample. Each copy is shifted left by its digit position and bitwise inverted when its digit is negative. The per-tap terms are folded into a transposed delay line, and that running total is kept in carry-save form. As a result no tap carries a carry-propagate adder and the filter has no adder tree.

One signed sample is accepted per clock when its valid flag is high. Cycles without valid are skipped and do not shift the filter. The result leaves the block as a pair of 24-bit vectors, a sum vector and a carry vector. A downstream carry-propagate adder resolves them, and their sum modulo 2^24 is the filter output. The coefficient set is chosen through parameters. Zero taps build no arithmetic.

Top module: `csd_fir`

## Requirements
- R1: While reset is high, and in the cycle after it falls, out_valid, out_sum and out_carry are all zero.
- R2: out_valid is high in the third clock cycle after a cycle in which in_valid was high, and low in the third cycle after a cycle in which in_valid was low.
- R3: When out_valid is high, (out_sum + out_carry) mod 2^24 equals the sum over k of c[k]·x[j−k], where x[j] is the newest accepted sample and samples accepted before reset count as zero.
- R4: With default parameters the coefficients c[0..7] are −5, 0, 14, 20, 20, 14, 0, −3. Tap k uses bit k of TAP_EN (1 = active), NEG_HI and NEG_LO (1 = negative digit), and entry k of SHIFT_HI and SHIFT_LO (digit positions, 3 bits each), giving c[k] = ±2^SHIFT_HI[k] ± 2^SHIFT_LO[k].
- R5: A negative digit is realised as an inverted copy of the shifted sample plus a one at a vacated carry LSB, so that the result is exact for negative coefficients, including the input −2048.
- R6: A tap whose TAP_EN bit is 0 adds nothing: the impulse response is zero at lags 1 and 6.
- R7: A cycle with in_valid low does not shift the filter, and it leaves out_sum and out_carry unchanged three cycles later.
- R8: Streams of full-scale samples (2047 and −2048) give exact results modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_sample carries a new sample |
| in_sample | input | 12 | Two's-complement input sample |
| out_valid | output | 1 | A new result is on out_sum/out_carry |
| out_sum | output | 24 | Sum vector of the carry-save result |
| out_carry | output | 24 | Carry vector of the carry-save result |

## Verification
Assertions check on every cycle that each tap register holds exactly its coefficient times the accepted sample plus the incoming sum/carry pair, taken modulo 2^24. They also check that zero taps pass the pair through unchanged, that out_valid follows in_valid three cycles later, and that idle cycles hold the outputs. Only the bench scenarios can show that the parameter encoding gives the intended coefficient values, that impulse responses have the right shape with zeros at the empty taps, and that full-scale streams and gapped random streams resolve to the correct convolution.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;
  localparam int unsigned DEF_TAPS  = 8;
  localparam int unsigned DEF_IN_W  = 12;
  localparam int unsigned DEF_ACC_W = 24;
  localparam int unsigned DEF_SH_W  = 3;

  // signed weight of a two-digit coefficient
  function automatic int digit_pair(input bit neg_hi, input int unsigned sh_hi,
                                    input bit neg_lo, input int unsigned sh_lo);
    int hi, lo;
    hi = 1 << sh_hi;
    lo = 1 << sh_lo;
    return (neg_hi ? -hi : hi) + (neg_lo ? -lo : lo);
  endfunction
endpackage

// File: rtl/csd_term.sv
module csd_term #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned SHIFT = 0,
  parameter bit          NEG   = 1'b0
) (
  input  logic [IN_W-1:0]  x,
  output logic [ACC_W-1:0] term
);
  localparam int unsigned EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] shifted;

  assign ext     = {{EXT_W{x[IN_W-1]}}, x};
  assign shifted = ext << SHIFT;

  generate
    if (NEG) begin : g_inv
      // the +1 of the negation is injected by the compressor
      assign term = ~shifted;
    end else begin : g_pass
      assign term = shifted;
    end
  endgenerate
endmodule

// File: rtl/csa3.sv
module csa3 #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         lsb_in,
  output logic [W-1:0] s,
  output logic [W-1:0] k
);
  logic [W-2:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]);
  assign k   = {maj, lsb_in};
endmodule

// File: rtl/csd_tap.sv
module csd_tap #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned ACC_W  = 24,
  parameter bit          ACTIVE = 1'b1,
  parameter bit          NEG_HI = 1'b0,
  parameter int unsigned SH_HI  = 0,
  parameter bit          NEG_LO = 1'b0,
  parameter int unsigned SH_LO  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IN_W-1:0]  x,
  input  logic [ACC_W-1:0] in_sum,
  input  logic [ACC_W-1:0] in_carry,
  output logic [ACC_W-1:0] out_sum,
  output logic [ACC_W-1:0] out_carry
);
  import csd_fir_pkg::*;

  logic [ACC_W-1:0] sum_d, carry_d;
  logic [ACC_W-1:0] sum_q, carry_q;

  generate
    if (ACTIVE) begin : g_active
      localparam int COEF = digit_pair(NEG_HI, SH_HI, NEG_LO, SH_LO);
      logic [ACC_W-1:0] t_hi, t_lo, s1, k1;
      logic [ACC_W-1:0] want;

      csd_term #(.IN_W(IN_W), .ACC_W(ACC_W), .SHIFT(SH_HI), .NEG(NEG_HI)) u_hi (
        .x(x), .term(t_hi));
      csd_term #(.IN_W(IN_W), .ACC_W(ACC_W), .SHIFT(SH_LO), .NEG(NEG_LO)) u_lo (
        .x(x), .term(t_lo));

      // 4:2 compression as two chained 3:2 stages; the vacated carry LSBs
      // take the +1 corrections of the inverted copies
      csa3 #(.W(ACC_W)) u_c1 (
        .a(t_hi), .b(t_lo), .c(in_sum), .lsb_in(NEG_HI), .s(s1), .k(k1));
      csa3 #(.W(ACC_W)) u_c2 (
        .a(s1), .b(k1), .c(in_carry), .lsb_in(NEG_LO), .s(sum_d), .k(carry_d));

      assign want = in_sum + in_carry + ACC_W'($signed(x) * COEF);

      // R3 R5: the stored pair equals coefficient times sample plus incoming pair
      a_r3_stage_exact: assert property (@(posedge clk) disable iff (rst)
        adv |=> (sum_q + carry_q) == $past(want));
    end else begin : g_zero
      logic tap_unused_x;
      assign tap_unused_x = ^x;
      assign sum_d   = in_sum;
      assign carry_d = in_carry;

      a_r6_zero_pass: assert property (@(posedge clk) disable iff (rst)
        adv |=> (sum_q == $past(in_sum)) && (carry_q == $past(in_carry)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (adv) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  assign out_sum   = sum_q;
  assign out_carry = carry_q;

  a_r7_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sum_q) && $stable(carry_q));
endmodule

// File: rtl/csd_fir.sv
module csd_fir #(
  parameter int unsigned TAPS  = csd_fir_pkg::DEF_TAPS,
  parameter int unsigned IN_W  = csd_fir_pkg::DEF_IN_W,
  parameter int unsigned ACC_W = csd_fir_pkg::DEF_ACC_W,
  parameter int unsigned SH_W  = csd_fir_pkg::DEF_SH_W,
  parameter logic [TAPS-1:0]           TAP_EN   = 8'b1011_1101,
  parameter logic [TAPS-1:0]           NEG_HI   = 8'b1000_0001,
  parameter logic [TAPS-1:0]           NEG_LO   = 8'b0010_0101,
  parameter logic [TAPS-1:0][SH_W-1:0] SHIFT_HI = {3'd2, 3'd0, 3'd4, 3'd4, 3'd4, 3'd4, 3'd0, 3'd2},
  parameter logic [TAPS-1:0][SH_W-1:0] SHIFT_LO = {3'd0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd1, 3'd0, 3'd0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_sum,
  output logic [ACC_W-1:0] out_carry
);
  logic [IN_W-1:0]  x_q;
  logic             xv_q;
  logic             tv_q;
  logic [ACC_W-1:0] s_chain [TAPS+1];
  logic [ACC_W-1:0] c_chain [TAPS+1];

  // input stage
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      xv_q <= 1'b0;
    end else begin
      x_q  <= in_sample;
      xv_q <= in_valid;
    end
  end

  assign s_chain[TAPS] = '0;
  assign c_chain[TAPS] = '0;

  // transposed delay line: tap k adds c[k]*x to the pair from tap k+1
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      csd_tap #(
        .IN_W(IN_W), .ACC_W(ACC_W),
        .ACTIVE(TAP_EN[k]),
        .NEG_HI(NEG_HI[k]), .SH_HI(int'(SHIFT_HI[k])),
        .NEG_LO(NEG_LO[k]), .SH_LO(int'(SHIFT_LO[k]))
      ) u_tap (
        .clk(clk), .rst(rst), .adv(xv_q), .x(x_q),
        .in_sum(s_chain[k+1]), .in_carry(c_chain[k+1]),
        .out_sum(s_chain[k]), .out_carry(c_chain[k]));
    end
  endgenerate

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      tv_q      <= 1'b0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= '0;
    end else begin
      tv_q      <= xv_q;
      out_valid <= tv_q;
      out_sum   <= s_chain[0];
      out_carry <= c_chain[0];
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);
  a_r7_output_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 ($stable(out_sum) && $stable(out_carry)));
endmodule

// File: tb/tb_csd_fir.sv
module tb_csd_fir;
  localparam int TAPS  = 8;
  localparam int IN_W  = 12;
  localparam int ACC_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_sample = '0;
  logic out_valid;
  logic [ACC_W-1:0] out_sum, out_carry;

  always #2 clk = ~clk;

  csd_fir dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sum(out_sum), .out_carry(out_carry));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int coef [TAPS] = '{-5, 0, 14, 20, 20, 14, 0, -3};
  int hist [TAPS] = '{default: 0};
  int cur = 0;
  bit pv [3] = '{default: 1'b0};
  int pe [3] = '{default: 0};
  string pt [3] = '{default: "R3"};

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(input bit v, input int x, input string tag);
    logic [ACC_W-1:0] got, want;
    in_valid  = v;
    in_sample = IN_W'(x);
    @(posedge clk);
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      cur = 0;
      for (int k = 0; k < TAPS; k++) cur += coef[k] * hist[k];
    end
    pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v;     pe[0] = cur;   pt[0] = tag;
    @(negedge clk);
    check(out_valid == pv[2], "R2", "out_valid", int'(out_valid), int'(pv[2]));
    got  = out_sum + out_carry;
    want = ACC_W'(pe[2]);
    check(got == want, pv[2] ? pt[2] : "R7", "sum+carry", int'(got), int'(want));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_sum == '0, "R1", "out_sum after reset", int'(out_sum), 0);
    check(out_carry == '0, "R1", "out_carry after reset", int'(out_carry), 0);

    // unit impulse: coefficients appear in order, zeros at lags 1 and 6
    cycle(1'b1, 1, "R4");
    for (int lag = 1; lag < TAPS; lag++)
      cycle(1'b1, 0, (lag == 1 || lag == 6) ? "R6" : "R4");
    repeat (4) cycle(1'b0, 0, "R7");

    // negative full-scale impulse exercises the inverted copies
    cycle(1'b1, -2048, "R5");
    for (int lag = 1; lag < TAPS + 2; lag++) cycle(1'b1, 0, "R5");

    // random samples with gaps in valid
    for (int n = 0; n < 300; n++) begin
      bit v;
      int x;
      v = ($urandom_range(0, 3) != 0);
      x = int'($urandom_range(0, 4095)) - 2048;
      cycle(v, x, v ? "R3" : "R7");
    end

    // full-scale streams
    for (int n = 0; n < 20; n++) cycle(1'b1, 2047, "R8");
    for (int n = 0; n < 20; n++) cycle(1'b1, -2048, "R8");
    for (int n = 0; n < 40; n++) cycle(1'b1, (n % 2 == 0) ? 2047 : -2048, "R8");
    repeat (4) cycle(1'b0, 0, "R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule